// File: doc/BRIEF.md
# Variable-Length Serial Shift Port

This block is the bit-level datapath of a synchronous serial port. It sends and receives words of 8, 16, 24 or 32 bits, one bit per serial clock period. The serial clock is never used as a clock. It arrives as single-cycle rise and fall enables that are synchronous to the system clock. Two pairs of enables come in, one from an internal rate generator and one from an external clock pin, and a select input chooses which pair drives the shifters.

The transmitter takes a parallel word while it reports ready. It then moves the word out on the serial line, most significant bit first, one bit per rising edge. The receiver samples its serial input on falling edges into a register that shifts left. When the word is complete it copies the result, right-justified with zero fill, into a 32-bit buffer and raises a valid strobe for one cycle. Transmit and receive run on opposite edges, so the two directions of a link line up half a period apart.

Top module: `serial_shift_port`

## Requirements
- R1: After reset, tx_ready is 1, tx_sdo is 0, rx_valid is 0 and rx_word is 0.
- R2: When clk_sel is 0, only int_rise and int_fall act. When clk_sel is 1, only ext_rise and ext_fall act. Pulses on the pair that is not selected change nothing.
- R3: Each selected rise while a word is pending drives the next bit onto tx_sdo, most significant of the word length first. The output changes in the system clock cycle that follows the rise enable.
- R4: A load accepted while tx_ready is 1 drops tx_ready in the next cycle. tx_ready returns to 1 in the cycle after the rise that sends the last bit, and it stays at 1 while idle.
- R5: A load request while tx_ready is 0 is ignored: the word in flight and its bit count are not disturbed.
- R6: Between words, tx_sdo holds the last bit sent.
- R7: Each selected fall samples rx_sdi into the receive shifter. The shifter moves left, so the first bit received ends up most significant.
- R8: The word length is set by len_code: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. len_code must not change during a transfer. Bits of tx_word above the length are not sent.
- R9: In the cycle after the fall that captures the last bit of a word, rx_word holds the received bits right-justified, with the upper bits zero.
- R10: rx_valid is high for exactly one cycle per received word. rx_word changes only in that cycle and holds its value until the next word completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 1 | 0: internal enables, 1: external enables |
| int_rise | input | 1 | Rise enable from the internal generator |
| int_fall | input | 1 | Fall enable from the internal generator |
| ext_rise | input | 1 | Rise enable from the external clock pin |
| ext_fall | input | 1 | Fall enable from the external clock pin |
| len_code | input | 2 | Word length code (8, 16, 24, 32 bits) |
| tx_load | input | 1 | Load request for tx_word |
| tx_word | input | 32 | Parallel word to send |
| tx_ready | output | 1 | Transmitter idle and able to accept a load |
| tx_sdo | output | 1 | Serial data out |
| rx_sdi | input | 1 | Serial data in |
| rx_word | output | 32 | Receive buffer, right-justified |
| rx_valid | output | 1 | One-cycle strobe when a word is received |

## Verification
A transmit bit counter that is off by one shows up in two ways. The bit sent after the slip compares wrong on tx_sdo, and tx_ready rises one rise early or late. Both are visible within one serial period. A receive counter fault moves the rx_valid strobe away from the last fall and shifts the whole buffer, so the word compare fails at the end of that word. A wrong edge select, or a load that is wrongly accepted while busy, corrupts the serial stream at the very next selected rise.

// File: rtl/serial_shift_port.sv
module serial_shift_port #(
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 2,
  parameter int LEN_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_sel,
  input  logic              int_rise,
  input  logic              int_fall,
  input  logic              ext_rise,
  input  logic              ext_fall,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_word,
  output logic              tx_ready,
  output logic              tx_sdo,
  input  logic              rx_sdi,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid
);
  localparam int CW = $clog2(DATA_W + 1);

  logic              rise, fall;
  logic [CW-1:0]     nbits, tx_cnt, rx_cnt;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, len_mask;

  assign rise     = clk_sel ? ext_rise : int_rise;
  assign fall     = clk_sel ? ext_fall : int_fall;
  assign nbits    = CW'(LEN_STEP) * (CW'(len_code) + CW'(1));
  assign len_mask = {DATA_W{1'b1}} >> (CW'(DATA_W) - nbits);
  assign tx_ready = (tx_cnt == '0);
  assign rx_next  = {rx_sh[DATA_W-2:0], rx_sdi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      tx_cnt <= '0;
      tx_sdo <= 1'b0;
    end else if (tx_load && tx_ready) begin
      tx_sh  <= tx_word << (CW'(DATA_W) - nbits);
      tx_cnt <= nbits;
    end else if (rise && !tx_ready) begin
      tx_sdo <= tx_sh[DATA_W-1];
      tx_sh  <= tx_sh << 1;
      tx_cnt <= tx_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_cnt   <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fall) begin
        if (rx_cnt == nbits - CW'(1)) begin
          rx_word  <= rx_next & len_mask;
          rx_valid <= 1'b1;
          rx_sh    <= '0;
          rx_cnt   <= '0;
        end else begin
          rx_sh  <= rx_next;
          rx_cnt <= rx_cnt + CW'(1);
        end
      end
    end
  end
endmodule

module serial_shift_port_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_sel,
  input logic              int_rise,
  input logic              int_fall,
  input logic              ext_rise,
  input logic              ext_fall,
  input logic              tx_load,
  input logic              tx_ready,
  input logic              tx_sdo,
  input logic [DATA_W-1:0] rx_word,
  input logic              rx_valid
);
  logic sel_rise, sel_fall;
  assign sel_rise = clk_sel ? ext_rise : int_rise;
  assign sel_fall = clk_sel ? ext_fall : int_fall;

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && tx_ready |=> !tx_ready);
  // R4
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && !tx_load |=> tx_ready);
  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_rise |=> $stable(tx_sdo));
  // R10
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R10
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> rx_valid);
  // R2
  valid_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_fall |=> !rx_valid);
endmodule

bind serial_shift_port serial_shift_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .int_rise(int_rise),
  .int_fall(int_fall), .ext_rise(ext_rise), .ext_fall(ext_fall),
  .tx_load(tx_load), .tx_ready(tx_ready), .tx_sdo(tx_sdo),
  .rx_word(rx_word), .rx_valid(rx_valid)
);

// File: tb/test_serial_shift_port.sv
module test_serial_shift_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_sel = 1'b0;
  logic        int_rise = 1'b0, int_fall = 1'b0, ext_rise = 1'b0, ext_fall = 1'b0;
  logic [1:0]  len_code = 2'd0;
  logic        tx_load = 1'b0;
  logic [31:0] tx_word = '0;
  logic        tx_ready, tx_sdo, rx_valid;
  logic        rx_sdi = 1'b0;
  logic [31:0] rx_word;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  serial_shift_port i_serial_shift_port (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .int_rise(int_rise),
    .int_fall(int_fall), .ext_rise(ext_rise), .ext_fall(ext_fall),
    .len_code(len_code), .tx_load(tx_load), .tx_word(tx_word),
    .tx_ready(tx_ready), .tx_sdo(tx_sdo), .rx_sdi(rx_sdi),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int len_bits(input logic [1:0] c);
    return 8 * (int'(c) + 1);
  endfunction

  function automatic logic [31:0] rx_expect(input logic [31:0] w, input logic [1:0] c);
    return w & (32'hFFFF_FFFF >> (32 - len_bits(c)));
  endfunction

  task automatic drive(input bit r, input bit f);
    if (clk_sel) begin
      ext_rise = r; ext_fall = f;
      int_rise = 1'($urandom); int_fall = 1'($urandom);
    end else begin
      int_rise = r; int_fall = f;
      ext_rise = 1'($urandom); ext_fall = 1'($urandom);
    end
  endtask

  task automatic run_word(input logic [1:0] c, input logic [31:0] t, input logic [31:0] r, input bit s);
    int nb;
    logic [31:0] prev_buf;
    nb = len_bits(c);
    @(negedge clk);
    clk_sel = s; len_code = c; tx_word = t; tx_load = 1'b1; drive(0, 0);
    @(negedge clk);
    tx_load = 1'b0; drive(0, 0);
    check(tx_ready == 1'b0, "R4 ready low after load", 32'(tx_ready), 32'd0);
    prev_buf = rx_word;
    for (int i = 0; i < nb; i++) begin
      drive(1, 0);
      if (i == nb / 2) begin tx_load = 1'b1; tx_word = ~t; end
      @(negedge clk);
      tx_load = 1'b0;
      check(tx_sdo == t[nb-1-i], "R3/R5/R8 tx bit", 32'(tx_sdo), 32'(t[nb-1-i]));
      check(tx_ready == (i == nb - 1), "R4 ready timing", 32'(tx_ready), 32'(i == nb - 1));
      rx_sdi = r[nb-1-i];
      drive(0, 1);
      @(negedge clk);
      drive(0, 0);
      if (i < nb - 1) begin
        check(rx_valid == 1'b0 && rx_word == prev_buf, "R10 no early valid", rx_word, prev_buf);
      end else begin
        check(rx_valid == 1'b1, "R10 valid strobe", 32'(rx_valid), 32'd1);
        check(rx_word == rx_expect(r, c), "R7/R9 rx word", rx_word, rx_expect(r, c));
      end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      drive(0, 0);
    end
    check(rx_valid == 1'b0, "R10 one-cycle valid", 32'(rx_valid), 32'd0);
    check(rx_word == rx_expect(r, c), "R10 buffer holds", rx_word, rx_expect(r, c));
    check(tx_sdo == t[0], "R6/R2 tx holds last bit", 32'(tx_sdo), 32'(t[0]));
    check(tx_ready == 1'b1, "R4 idle ready", 32'(tx_ready), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(tx_ready == 1'b1, "R1 ready", 32'(tx_ready), 32'd1);
    check(tx_sdo == 1'b0, "R1 sdo", 32'(tx_sdo), 32'd0);
    check(rx_valid == 1'b0, "R1 valid", 32'(rx_valid), 32'd0);
    check(rx_word == 32'd0, "R1 buffer", rx_word, 32'd0);
    rst_n = 1'b1;
    run_word(2'd0, 32'hFFFF_FFA5, 32'hFFFF_FF3C, 1'b0);
    run_word(2'd3, 32'h8000_0001, 32'hFFFF_FFFF, 1'b1);
    run_word(2'd1, 32'hDEAD_7F01, 32'h1234_8001, 1'b0);
    run_word(2'd2, 32'h00FF_0080, 32'hAB80_0001, 1'b1);
    for (int n = 0; n < 40; n++)
      run_word(2'($urandom), $urandom, $urandom, 1'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule